// File: doc/BRIEF.md
# Call/Return Stack Pointer Unit

This block keeps the stack pointer of a small CPU and carries out the stack side of subroutine calls, interrupt entry and returns. The pointer is a 16-bit register. Software reaches it as two bytes of the register file. A call or interrupt entry lowers the pointer first and then stores the return address at the new top of stack. After that it hands the target address to the program counter. A return reads the top of stack back into the program counter and only then raises the pointer.

The unit has two addressing modes. In the narrow (64-Kbyte) mode each entry is one 16-bit word and the pointer moves by 2. In the wide (2-Mbyte) mode each entry is two 16-bit words and the pointer moves by 4. The first word holds the low half of the address and the second holds the upper bits, zero-extended. The stack always lies in page 00H. Each memory word takes one cycle, and the unit shows it is busy until the program counter load.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset `sp_o` is 0000H, and `busy_o`, `pc_load_o`, `misalign_o` and `mem_req_o` are all low.
- R2: A register-file byte write to address 0018H replaces the pointer's low byte, and one to 0019H replaces its high byte. Writes to any other address leave `sp_o` unchanged.
- R3: `cmd_op_i` is 01 for a call and 10 for an interrupt entry. Either one lowers the pointer by the step, then writes the low word of `ret_pc_i` to memory at the new pointer value, then pulses `pc_load_o` with `pc_o` equal to `tgt_pc_i`.
- R4: The step is 2 when `mode_wide_i` is 0 and 4 when it is 1. The mode is sampled when the command is accepted.
- R5: In wide mode a push writes the low 16 PC bits at SP and the upper PC bits, zero-extended, at SP+2. A wide pop rebuilds the PC from the same two words. In narrow mode the upper PC bits are zero.
- R6: `cmd_op_i` 11 is a return. It reads the word at the current pointer, puts it on `pc_o` with a `pc_load_o` pulse, and then raises the pointer by the step.
- R7: Consecutive calls keep lowering the pointer, and returns give the stored addresses back in reverse order.
- R8: Pointer arithmetic wraps modulo 2^16, so a narrow call with the pointer at 0000H stores its entry at FFFEH.
- R9: Every stack access drives `mem_addr_o` with all bits above bit 15 at zero.
- R10: `misalign_o` is high while the pointer is odd. Only a software write can make the pointer odd. Pushes and pops use the pointer with bit 0 cleared.
- R11: `busy_o` goes high in the cycle after a command is accepted and stays high through the `pc_load_o` cycle. Commands that arrive while busy, and op 00, have no effect.
- R12: `pc_load_o` is a one-cycle pulse. Counted from the accepting edge, it comes in the 2nd cycle for a narrow call, the 3rd for a wide call, the 3rd for a narrow return and the 4th for a wide return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_wide_i | input | 1 | 1 selects 2-Mbyte mode, 0 selects 64-Kbyte mode |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 00 none, 01 call, 10 interrupt, 11 return |
| ret_pc_i | input | PC_W | Address of the next instruction, to be pushed |
| tgt_pc_i | input | PC_W | Call or interrupt target |
| pc_load_o | output | 1 | Load strobe for the program counter |
| pc_o | output | PC_W | New program counter value |
| busy_o | output | 1 | A stack operation is in progress |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 for a write access |
| mem_addr_o | output | AW | Byte address, page 00H |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a read request |
| rf_we_i | input | 1 | Register-file byte write strobe |
| rf_addr_i | input | RF_AW | Register-file byte address |
| rf_wdata_i | input | 8 | Register-file write data |
| sp_o | output | 16 | Current stack pointer |
| misalign_o | output | 1 | Pointer is odd |

## Verification
The bench uses the default parameters: PC_W of 21, AW of 21 and RF_AW of 16. A 21-bit return address has bits above the first stored word, so the wide-mode split, the zero-extension and the check that the memory address keeps its page bits at zero are all exercised. The 16-bit register-file address lets the bench write next to the pointer, at 0017H and 001AH, and show that those writes leave the pointer alone. Starting the pointer at 0000H, or at an odd value, reaches the wrap case and the case where bit 0 is cleared.

// File: rtl/stack_ptr_pkg.sv
package stack_ptr_pkg;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_CALL = 2'b01,
    OP_IRQ  = 2'b10,
    OP_RET  = 2'b11
  } stk_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PUSH_LO,
    S_PUSH_HI,
    S_POP_LO,
    S_POP_HI,
    S_POP_END,
    S_LOAD
  } stk_state_e;
endpackage

// File: rtl/stack_ptr_reg.sv
module stack_ptr_reg #(
  parameter int unsigned RF_AW   = 16,
  parameter int unsigned SP_ADDR = 16'h0018
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rf_we_i,
  input  logic [RF_AW-1:0] rf_addr_i,
  input  logic [7:0]       rf_wdata_i,
  input  logic             upd_dec_i,
  input  logic             upd_inc_i,
  input  logic             step_wide_i,
  output logic [15:0]      sp_q_o,
  output logic [15:0]      sp_al_o
);
  localparam logic [RF_AW-1:0] ADDR_LO = RF_AW'(SP_ADDR);
  localparam logic [RF_AW-1:0] ADDR_HI = RF_AW'(SP_ADDR + 1);

  logic [15:0] sp_q, sp_al, step;

  assign sp_al = {sp_q[15:1], 1'b0};
  assign step  = step_wide_i ? 16'd4 : 16'd2;

  // stack updates win over a software write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
    end else if (upd_dec_i) begin
      sp_q <= sp_al - step;
    end else if (upd_inc_i) begin
      sp_q <= sp_al + step;
    end else if (rf_we_i && rf_addr_i == ADDR_LO) begin
      sp_q[7:0] <= rf_wdata_i;
    end else if (rf_we_i && rf_addr_i == ADDR_HI) begin
      sp_q[15:8] <= rf_wdata_i;
    end
  end

  assign sp_q_o  = sp_q;
  assign sp_al_o = sp_al;

  a_r4_push_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_dec_i |=> sp_q == $past(sp_al) - ($past(step_wide_i) ? 16'd4 : 16'd2));

  a_r6_pop_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_inc_i && !upd_dec_i) |=> sp_q == $past(sp_al) + ($past(step_wide_i) ? 16'd4 : 16'd2));

  a_r10_odd_from_sw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sp_q[0]) |-> $past(rf_we_i));
endmodule

// File: rtl/stack_ret_pack.sv
module stack_ret_pack #(
  parameter int unsigned PC_W = 21
) (
  input  logic [PC_W-1:0] pc_i,
  output logic [15:0]     lo_o,
  output logic [15:0]     hi_o,
  input  logic [15:0]     join_lo_i,
  input  logic [15:0]     join_hi_i,
  output logic [PC_W-1:0] join_o
);
  generate
    if (PC_W > 16) begin : g_split
      localparam int unsigned UP_W = PC_W - 16;
      assign lo_o   = pc_i[15:0];
      assign hi_o   = 16'(pc_i[PC_W-1:16]);
      assign join_o = {join_hi_i[UP_W-1:0], join_lo_i};
    end else begin : g_single
      assign lo_o   = 16'(pc_i);
      assign hi_o   = '0;
      assign join_o = join_lo_i[PC_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_ptr_pkg::*;
#(
  parameter int unsigned PC_W = 21
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mode_wide_i,
  input  logic            cmd_valid_i,
  input  logic [1:0]      cmd_op_i,
  input  logic [PC_W-1:0] ret_pc_i,
  input  logic [PC_W-1:0] tgt_pc_i,
  input  logic [15:0]     sp_al_i,
  input  logic [15:0]     mem_rdata_i,
  output logic            upd_dec_o,
  output logic            upd_inc_o,
  output logic            step_wide_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [15:0]     mem_addr_o,
  output logic [15:0]     mem_wdata_o,
  output logic            pc_load_o,
  output logic [PC_W-1:0] pc_o,
  output logic            busy_o
);
  stk_state_e state_q, state_d;
  logic            wide_q, is_ret_q;
  logic [PC_W-1:0] ret_q, tgt_q, pc_q, join_pc;
  logic [15:0]     lo_q, push_lo, push_hi, join_lo, join_hi;
  logic            accept;

  assign accept = (state_q == S_IDLE) && cmd_valid_i && (stk_op_e'(cmd_op_i) != OP_NONE);

  stack_ret_pack #(.PC_W(PC_W)) u_pack (
    .pc_i     (ret_q),
    .lo_o     (push_lo),
    .hi_o     (push_hi),
    .join_lo_i(join_lo),
    .join_hi_i(join_hi),
    .join_o   (join_pc)
  );

  assign join_lo = wide_q ? lo_q : mem_rdata_i;
  assign join_hi = wide_q ? mem_rdata_i : 16'h0000;

  always_comb begin
    state_d     = state_q;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = sp_al_i;
    mem_wdata_o = push_lo;
    pc_load_o   = 1'b0;
    upd_inc_o   = 1'b0;
    unique case (state_q)
      S_IDLE: if (accept) state_d = (stk_op_e'(cmd_op_i) == OP_RET) ? S_POP_LO : S_PUSH_LO;
      S_PUSH_LO: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        state_d   = wide_q ? S_PUSH_HI : S_LOAD;
      end
      S_PUSH_HI: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_al_i + 16'd2;
        mem_wdata_o = push_hi;
        state_d     = S_LOAD;
      end
      S_POP_LO: begin
        mem_req_o = 1'b1;
        state_d   = wide_q ? S_POP_HI : S_POP_END;
      end
      S_POP_HI: begin
        mem_req_o  = 1'b1;
        mem_addr_o = sp_al_i + 16'd2;
        state_d    = S_POP_END;
      end
      S_POP_END: state_d = S_LOAD;
      S_LOAD: begin
        pc_load_o = 1'b1;
        upd_inc_o = is_ret_q;
        state_d   = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      wide_q   <= 1'b0;
      is_ret_q <= 1'b0;
      ret_q    <= '0;
      tgt_q    <= '0;
      pc_q     <= '0;
      lo_q     <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        wide_q   <= mode_wide_i;
        is_ret_q <= stk_op_e'(cmd_op_i) == OP_RET;
        ret_q    <= ret_pc_i;
        tgt_q    <= tgt_pc_i;
      end
      if (state_q == S_POP_HI) lo_q <= mem_rdata_i;
      if (state_q == S_POP_END) pc_q <= join_pc;
    end
  end

  assign upd_dec_o   = accept && (stk_op_e'(cmd_op_i) != OP_RET);
  assign step_wide_o = accept ? mode_wide_i : wide_q;
  assign pc_o        = is_ret_q ? pc_q : tgt_q;
  assign busy_o      = state_q != S_IDLE;

  a_r12_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |=> !pc_load_o);

  a_r11_busy_through_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> busy_o);

  a_r11_no_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !pc_load_o) |=> busy_o);

  a_r3_write_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> !is_ret_q);
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter int unsigned PC_W    = 21,
  parameter int unsigned AW      = 21,
  parameter int unsigned RF_AW   = 16,
  parameter int unsigned SP_ADDR = 16'h0018
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_wide_i,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic [PC_W-1:0]  ret_pc_i,
  input  logic [PC_W-1:0]  tgt_pc_i,
  output logic             pc_load_o,
  output logic [PC_W-1:0]  pc_o,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [15:0]      mem_wdata_o,
  input  logic [15:0]      mem_rdata_i,
  input  logic             rf_we_i,
  input  logic [RF_AW-1:0] rf_addr_i,
  input  logic [7:0]       rf_wdata_i,
  output logic [15:0]      sp_o,
  output logic             misalign_o
);
  logic        upd_dec, upd_inc, step_wide;
  logic [15:0] sp_q, sp_al, addr16;

  stack_ptr_reg #(.RF_AW(RF_AW), .SP_ADDR(SP_ADDR)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rf_we_i    (rf_we_i),
    .rf_addr_i  (rf_addr_i),
    .rf_wdata_i (rf_wdata_i),
    .upd_dec_i  (upd_dec),
    .upd_inc_i  (upd_inc),
    .step_wide_i(step_wide),
    .sp_q_o     (sp_q),
    .sp_al_o    (sp_al)
  );

  stack_seq #(.PC_W(PC_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_wide_i(mode_wide_i),
    .cmd_valid_i(cmd_valid_i),
    .cmd_op_i   (cmd_op_i),
    .ret_pc_i   (ret_pc_i),
    .tgt_pc_i   (tgt_pc_i),
    .sp_al_i    (sp_al),
    .mem_rdata_i(mem_rdata_i),
    .upd_dec_o  (upd_dec),
    .upd_inc_o  (upd_inc),
    .step_wide_o(step_wide),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (addr16),
    .mem_wdata_o(mem_wdata_o),
    .pc_load_o  (pc_load_o),
    .pc_o       (pc_o),
    .busy_o     (busy_o)
  );

  generate
    if (AW > 16) begin : g_page
      assign mem_addr_o = {{(AW-16){1'b0}}, addr16};
    end else begin : g_flat
      assign mem_addr_o = addr16[AW-1:0];
    end
  endgenerate

  assign sp_o       = sp_q;
  assign misalign_o = sp_q[0];

  a_r10_even_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !mem_addr_o[0]);

  a_r9_req_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  a_r3_push_leaves_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> !sp_o[0] || $past(rf_we_i));
endmodule

// File: tb/stack_ptr_unit_tb.sv
module stack_ptr_unit_tb;
  localparam int unsigned PC_W = 21;
  localparam int unsigned AW   = 21;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            mode_wide = 1'b0;
  logic            cmd_valid = 1'b0;
  logic [1:0]      cmd_op = 2'b00;
  logic [PC_W-1:0] ret_pc = '0, tgt_pc = '0;
  logic            pc_load, busy, mem_req, mem_we, misalign;
  logic [PC_W-1:0] pc;
  logic [AW-1:0]   mem_addr;
  logic [15:0]     mem_wdata, mem_rdata = '0, sp;
  logic            rf_we = 1'b0;
  logic [15:0]     rf_addr = '0;
  logic [7:0]      rf_wdata = '0;

  int n_chk = 0, n_fail = 0;
  int page_bad = 0;
  logic [15:0] mem [0:2047];

  always #2 clk = ~clk;

  stack_ptr_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_wide_i(mode_wide),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .ret_pc_i(ret_pc), .tgt_pc_i(tgt_pc),
    .pc_load_o(pc_load), .pc_o(pc), .busy_o(busy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .rf_we_i(rf_we), .rf_addr_i(rf_addr), .rf_wdata_i(rf_wdata),
    .sp_o(sp), .misalign_o(misalign)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_addr[AW-1:16] != '0) page_bad++;
      if (mem_we) mem[mem_addr[11:1]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[11:1]];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rf_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); rf_we = 1'b1; rf_addr = a; rf_wdata = d;
    @(negedge clk); rf_we = 1'b0;
  endtask

  task automatic set_sp(input logic [15:0] v);
    rf_write(16'h0018, v[7:0]);
    rf_write(16'h0019, v[15:8]);
  endtask

  // issues a command, returns pc_load cycle count and pc; leaves on the negedge after the pulse
  task automatic run_cmd(input logic [1:0] op, input logic wide, input logic [PC_W-1:0] r,
                         input logic [PC_W-1:0] t, output int lat, output logic [PC_W-1:0] p);
    @(negedge clk);
    mode_wide = wide; cmd_valid = 1'b1; cmd_op = op; ret_pc = r; tgt_pc = t;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    lat = 1;
    while (!pc_load && lat < 20) begin
      @(negedge clk); lat++;
    end
    p = pc;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(sp == 16'h0000, "R1 sp", sp, 0);
    chk(!busy && !pc_load && !misalign && !mem_req, "R1 flags",
        {busy, pc_load, misalign, mem_req}, 0);
  endtask

  task automatic t_sw_write;
    set_sp(16'h0400);
    chk(sp == 16'h0400, "R2 byte writes", sp, 16'h0400);
    rf_write(16'h0017, 8'hAA);
    rf_write(16'h001A, 8'h55);
    chk(sp == 16'h0400, "R2 neighbours ignored", sp, 16'h0400);
  endtask

  task automatic t_call_narrow;
    int lat; logic [PC_W-1:0] p;
    set_sp(16'h0400);
    run_cmd(2'b01, 1'b0, 21'h01234, 21'h02000, lat, p);
    chk(lat == 2, "R12 narrow call latency", lat, 2);
    chk(p == 21'h02000, "R3 target loaded", p, 21'h02000);
    chk(sp == 16'h03FE, "R4 narrow step", sp, 16'h03FE);
    chk(mem[16'h03FE >> 1] == 16'h1234, "R3 return at new sp", mem[16'h03FE >> 1], 16'h1234);
    chk(!busy, "R11 busy clear", busy, 0);
  endtask

  task automatic t_wide;
    int lat; logic [PC_W-1:0] p;
    set_sp(16'h0400);
    run_cmd(2'b10, 1'b1, 21'h1ABCD, 21'h0C000, lat, p);
    chk(lat == 3, "R12 wide irq latency", lat, 3);
    chk(p == 21'h0C000, "R3 irq target", p, 21'h0C000);
    chk(sp == 16'h03FC, "R4 wide step", sp, 16'h03FC);
    chk(mem[16'h03FC >> 1] == 16'hABCD, "R5 low word", mem[16'h03FC >> 1], 16'hABCD);
    chk(mem[16'h03FE >> 1] == 16'h0001, "R5 high word", mem[16'h03FE >> 1], 16'h0001);
    run_cmd(2'b11, 1'b1, '0, '0, lat, p);
    chk(lat == 4, "R12 wide return latency", lat, 4);
    chk(p == 21'h1ABCD, "R5 wide pop", p, 21'h1ABCD);
    chk(sp == 16'h0400, "R6 wide increment", sp, 16'h0400);
    chk(page_bad == 0, "R9 page zero", page_bad, 0);
  endtask

  task automatic t_nest;
    int lat; logic [PC_W-1:0] p;
    set_sp(16'h0300);
    run_cmd(2'b01, 1'b0, 21'h00111, 21'h00A00, lat, p);
    run_cmd(2'b01, 1'b0, 21'h00222, 21'h00B00, lat, p);
    run_cmd(2'b10, 1'b0, 21'h00333, 21'h00C00, lat, p);
    chk(sp == 16'h02FA, "R7 three pushes", sp, 16'h02FA);
    run_cmd(2'b11, 1'b0, '0, '0, lat, p);
    chk(lat == 3, "R12 narrow return latency", lat, 3);
    chk(p == 21'h00333, "R7 first pop", p, 21'h00333);
    run_cmd(2'b11, 1'b0, '0, '0, lat, p);
    chk(p == 21'h00222, "R7 second pop", p, 21'h00222);
    run_cmd(2'b11, 1'b0, '0, '0, lat, p);
    chk(p == 21'h00111, "R6 third pop", p, 21'h00111);
    chk(sp == 16'h0300, "R6 unwound", sp, 16'h0300);
  endtask

  task automatic t_wrap;
    int lat; logic [PC_W-1:0] p;
    set_sp(16'h0000);
    run_cmd(2'b01, 1'b0, 21'h04321, 21'h00100, lat, p);
    chk(sp == 16'hFFFE, "R8 wrap down", sp, 16'hFFFE);
    chk(mem[11'h7FF] == 16'h4321, "R8 entry at FFFE", mem[11'h7FF], 16'h4321);
    run_cmd(2'b11, 1'b0, '0, '0, lat, p);
    chk(p == 21'h04321, "R8 pop from FFFE", p, 21'h04321);
    chk(sp == 16'h0000, "R8 wrap up", sp, 0);
  endtask

  task automatic t_misalign;
    int lat; logic [PC_W-1:0] p;
    set_sp(16'h0401);
    chk(misalign, "R10 flag set", misalign, 1);
    run_cmd(2'b01, 1'b0, 21'h05A5A, 21'h00200, lat, p);
    chk(sp == 16'h03FE, "R10 bit0 cleared", sp, 16'h03FE);
    chk(mem[16'h03FE >> 1] == 16'h5A5A, "R10 aligned push", mem[16'h03FE >> 1], 16'h5A5A);
    chk(!misalign, "R10 flag clear", misalign, 0);
  endtask

  task automatic t_busy_ignore;
    int lat;
    set_sp(16'h0500);
    @(negedge clk);
    mode_wide = 1'b1; cmd_valid = 1'b1; cmd_op = 2'b01; ret_pc = 21'h00777; tgt_pc = 21'h00300;
    @(negedge clk);
    chk(busy, "R11 busy after accept", busy, 1);
    cmd_op = 2'b11; mode_wide = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    lat = 2;
    while (!pc_load && lat < 20) begin
      @(negedge clk); lat++;
    end
    chk(lat == 3, "R11 wide call unaffected", lat, 3);
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk(!busy && sp == 16'h04FC, "R11 extra command ignored", sp, 16'h04FC);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'b00;
    @(negedge clk); cmd_valid = 1'b0;
    @(negedge clk);
    chk(!busy && sp == 16'h04FC, "R11 op none ignored", sp, 16'h04FC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_sw_write;
    t_call_narrow;
    t_wide;
    t_nest;
    t_wrap;
    t_misalign;
    t_busy_ignore;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule